// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Write Target

This block is the write side of a byte-addressed serial EEPROM that sits on a two-wire bus. It uses a fast system clock to sample the bus clock and data lines, and it recognises Start and Stop conditions. It accepts a write transaction made of a device select byte, a two-byte memory address and a run of data bytes. The data bytes go into a one-row page buffer. The buffer is committed to an on-chip byte memory only after a timed internal write cycle. Acknowledge bits go out through an open-drain output enable, and the target never drives the data line high.

A write-protect input that is high during the header of a transaction makes the target refuse the data bytes. Addresses advance only within a row of the page, so a long burst wraps back to the start of the same row. A Stop that does not fall right after an acknowledge throws the buffered data away, as does a repeated Start. While the write cycle runs, the target ignores the bus. Read transactions only see the data line released. The memory has a flow-through read port so that its contents can be observed.

Top module: `eewr_target`

## Requirements
- R1: After a Start, a select byte is acknowledged by pulling SDA low during the ninth bus clock when its bits [7:1], sent MSB first, equal DEV_ADDR and bit 0 (read/write) is 0.
- R2: A select byte with a different address field or with bit 0 set to 1 is not acknowledged. Every later byte up to the next Start is also not acknowledged, and nothing is written.
- R3: The two address bytes that follow an accepted select are each acknowledged. The high byte comes first. The low log2(MEM_DEPTH) bits of the 16-bit value load the pointer output.
- R4: If the write-protect input is high at any clock from the Start until the low address byte's acknowledge ends, every data byte is answered with NoAck, no write cycle starts and memory is unchanged. A high level only after that point has no effect.
- R5: With writes permitted, each data byte is acknowledged and stored, and all bytes of one transaction are written in a single write cycle.
- R6: After each stored byte, only the low log2(PAGE_BYTES) pointer bits increment. A byte past the row end lands at the row start and replaces the byte buffered there earlier.
- R7: A write cycle starts only on a Stop in the first bit slot after a data-byte acknowledge. A Stop after address bytes only, or after part of a byte, discards the buffer and busy stays low.
- R8: A repeated Start during the address or data phase abandons that transaction, and none of its data is written.
- R9: busy_o stays high for exactly WCYC_CLKS clocks and memory changes at the clock where it falls. During that time SDA is never driven, and even a matching select byte is not acknowledged.
- R10: When a write cycle completes, the pointer equals the address after the last byte written, wrapped within its row.
- R11: After reset, SDA is released, busy_o is low, the pointer is 0 and every memory byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pulls the data line low when 1 |
| wc_i | input | 1 | Write protect, active high |
| busy_o | output | 1 | Internal write cycle in progress |
| ptr_o | output | log2(MEM_DEPTH) | Internal byte address pointer |
| rd_addr_i | input | log2(MEM_DEPTH) | Memory observation address |
| rd_data_o | output | 8 | Memory byte at rd_addr_i (flow-through) |

## Verification
The hardest case to reach is a select byte arriving while a write cycle is still running. The bench reaches it by issuing a new Start and a matching select as soon as the committing Stop has gone out, so that the acknowledge slot falls well inside the busy window. The bench also has to land a Stop exactly in the first slot after an acknowledge, as opposed to a few bits later. It does this with a bit-granular driver that can stop after any number of bits. Row wrap overwrite needs a burst longer than one row, so the bench sends 34 bytes to one row.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_AHI,
      ST_ALO,
      ST_DATA,
      ST_BUSY
   } eewr_state_t;
endpackage

// File: rtl/eewr_bus_sync.sv
module eewr_bus_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [SYNC_STAGES-1:0] scl_q, sda_q;
   logic                   scl_d, sda_d;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
         sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
         scl_d <= scl_q[SYNC_STAGES-1];
         sda_d <= sda_q[SYNC_STAGES-1];
      end
   end

   assign scl_s     = scl_q[SYNC_STAGES-1];
   assign sda_s     = sda_q[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eewr_page_buf.sv
module eewr_page_buf #(
   parameter int PAGE_BYTES = 32,
   parameter int PW         = $clog2(PAGE_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    wr_en,
   input  logic [PW-1:0]           wr_idx,
   input  logic [7:0]              wr_data,
   output logic [PAGE_BYTES*8-1:0] data_o,
   output logic [PAGE_BYTES-1:0]   valid_o
);
   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
      logic [7:0] lane_q;
      logic       lane_v;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
            lane_v <= 1'b0;
         end else if (clear) begin
            lane_v <= 1'b0;
         end else if (wr_en && (wr_idx == PW'(g))) begin
            lane_q <= wr_data;
            lane_v <= 1'b1;
         end
      end

      assign data_o[g*8 +: 8] = lane_q;
      assign valid_o[g]       = lane_v;
   end
endmodule

// File: rtl/eewr_mem.sv
module eewr_mem #(
   parameter int MEM_DEPTH  = 256,
   parameter int PAGE_BYTES = 32,
   parameter int AW         = $clog2(MEM_DEPTH),
   parameter int PW         = $clog2(PAGE_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    commit,
   input  logic [AW-PW-1:0]        row,
   input  logic [PAGE_BYTES*8-1:0] page_data,
   input  logic [PAGE_BYTES-1:0]   page_valid,
   input  logic [AW-1:0]           rd_addr,
   output logic [7:0]              rd_data
);
   logic [7:0] mem_q [MEM_DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
      end else if (commit) begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (page_valid[i]) mem_q[{row, PW'(i)}] <= page_data[i*8 +: 8];
         end
      end
   end

   assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/eewr_target.sv
module eewr_target
   import eewr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h50,
   parameter int         MEM_DEPTH   = 256,
   parameter int         PAGE_BYTES  = 32,
   parameter int         WCYC_CLKS   = 400,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         scl_i,
   input  logic                         sda_i,
   output logic                         sda_oe_o,
   input  logic                         wc_i,
   output logic                         busy_o,
   output logic [$clog2(MEM_DEPTH)-1:0] ptr_o,
   input  logic [$clog2(MEM_DEPTH)-1:0] rd_addr_i,
   output logic [7:0]                   rd_data_o
);
   localparam int AW = $clog2(MEM_DEPTH);
   localparam int PW = $clog2(PAGE_BYTES);
   localparam int CW = $clog2(WCYC_CLKS + 1);

   if (MEM_DEPTH != (1 << AW) || AW > 16) begin : g_bad_depth
      $error("MEM_DEPTH must be a power of two no larger than 65536");
   end
   if (PAGE_BYTES < 2 || PAGE_BYTES != (1 << PW)) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (MEM_DEPTH <= PAGE_BYTES) begin : g_bad_rows
      $error("MEM_DEPTH must hold at least two pages");
   end
   if (WCYC_CLKS < 1) begin : g_bad_wcyc
      $error("WCYC_CLKS must be at least 1");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   eewr_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   eewr_state_t   state;
   logic [7:0]    shreg, hi_q;
   logic [3:0]    bitcnt;
   logic          in_ack, oe_q, blocked, have_data;
   logic [AW-1:0] ptr;
   logic [CW-1:0] wcnt;

   logic hdr_phase, byte_done, ack_end, sel_ok, commit, stop_commit;
   logic buf_clr, buf_we;

   assign hdr_phase   = (state == ST_SEL) || (state == ST_AHI) || (state == ST_ALO);
   assign byte_done   = scl_fall && !in_ack && (bitcnt == 4'd8)
                        && (state != ST_IDLE) && (state != ST_BUSY);
   assign ack_end     = scl_fall && in_ack;
   assign sel_ok      = (shreg[7:1] == DEV_ADDR) && !shreg[0];
   assign commit      = (state == ST_BUSY) && (wcnt == CW'(1));
   assign stop_commit = (state == ST_DATA) && !in_ack && (bitcnt == 4'd1)
                        && have_data && !blocked;
   assign buf_clr     = start_det && (state != ST_BUSY);
   assign buf_we      = byte_done && (state == ST_DATA) && !blocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         shreg     <= '0;
         hi_q      <= '0;
         bitcnt    <= '0;
         in_ack    <= 1'b0;
         oe_q      <= 1'b0;
         blocked   <= 1'b0;
         have_data <= 1'b0;
         ptr       <= '0;
         wcnt      <= '0;
      end else if (state == ST_BUSY) begin
         if (commit) state <= ST_IDLE;
         else        wcnt  <= wcnt - CW'(1);
      end else if (start_det) begin
         state     <= ST_SEL;
         bitcnt    <= '0;
         in_ack    <= 1'b0;
         oe_q      <= 1'b0;
         blocked   <= wc_i;
         have_data <= 1'b0;
      end else if (stop_det) begin
         bitcnt <= '0;
         in_ack <= 1'b0;
         oe_q   <= 1'b0;
         if (stop_commit) begin
            state <= ST_BUSY;
            wcnt  <= CW'(WCYC_CLKS);
         end else begin
            state <= ST_IDLE;
         end
      end else if (state != ST_IDLE) begin
         if (wc_i && hdr_phase) blocked <= 1'b1;
         if (scl_rise && !in_ack && (bitcnt != 4'd8)) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
         end
         if (byte_done) begin
            bitcnt <= '0;
            in_ack <= 1'b1;
            case (state)
               ST_SEL: begin
                  if (sel_ok) begin
                     oe_q <= 1'b1;
                  end else begin
                     state  <= ST_IDLE;
                     in_ack <= 1'b0;
                  end
               end
               ST_AHI: begin
                  hi_q <= shreg;
                  oe_q <= 1'b1;
               end
               ST_ALO: begin
                  ptr  <= AW'({hi_q, shreg});
                  oe_q <= 1'b1;
               end
               ST_DATA: begin
                  if (!blocked) begin
                     ptr       <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
                     have_data <= 1'b1;
                     oe_q      <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
         if (ack_end) begin
            oe_q   <= 1'b0;
            in_ack <= 1'b0;
            case (state)
               ST_SEL:  state <= ST_AHI;
               ST_AHI:  state <= ST_ALO;
               ST_ALO:  state <= ST_DATA;
               default: ;
            endcase
         end
      end
   end

   logic [PAGE_BYTES*8-1:0] page_data;
   logic [PAGE_BYTES-1:0]   page_valid;

   eewr_page_buf #(.PAGE_BYTES(PAGE_BYTES), .PW(PW)) u_page (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (buf_clr),
      .wr_en  (buf_we),
      .wr_idx (ptr[PW-1:0]),
      .wr_data(shreg),
      .data_o (page_data),
      .valid_o(page_valid)
   );

   eewr_mem #(.MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES), .AW(AW), .PW(PW)) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit),
      .row       (ptr[AW-1:PW]),
      .page_data (page_data),
      .page_valid(page_valid),
      .rd_addr   (rd_addr_i),
      .rd_data   (rd_data_o)
   );

   assign sda_oe_o = oe_q;
   assign busy_o   = (state == ST_BUSY);
   assign ptr_o    = ptr;
endmodule

// File: rtl/eewr_target_chk.sv
module eewr_target_chk #(
   parameter int WCYC_CLKS = 400
) (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic sda_oe_o,
   input logic scl_s,
   input logic stop_det,
   input logic blocked
);
   int bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bcnt <= 0;
      else if (busy_o) bcnt <= bcnt + 1;
      else             bcnt <= 0;
   end

   // R9: data line released for the whole write cycle
   a_r9_released_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !sda_oe_o);

   // R9: write cycle never runs past its length
   a_r9_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (bcnt < WCYC_CLKS));

   // R9: write cycle ends after exactly its length
   a_r9_busy_exact: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> ($past(bcnt) == WCYC_CLKS - 1));

   // R7: a write cycle begins only on a detected Stop
   a_r7_start_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_det));

   // R4: a protected transaction never starts a write cycle
   a_r4_no_cycle_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !$past(blocked));

   // R1: acknowledge drive only changes while the bus clock is low
   a_r1_ack_edge_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_s);
endmodule

bind eewr_target eewr_target_chk #(.WCYC_CLKS(WCYC_CLKS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy_o  (busy_o),
   .sda_oe_o(sda_oe_o),
   .scl_s   (scl_s),
   .stop_det(stop_det),
   .blocked (blocked)
);

// File: tb/eewr_target_tb_top.sv
module eewr_target_tb_top;
   localparam int         CLK_PERIOD = 10;
   localparam int         Q          = 8;
   localparam int         WCYC       = 400;
   localparam logic [6:0] DEV        = 7'h50;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_drv = 1'b1, sda_drv = 1'b1, wc = 1'b0;
   logic sda_oe, busy;
   logic [7:0] ptr, rd_data;
   logic [7:0] rd_addr = '0;
   wire  sda_line = sda_drv & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   eewr_target #(.DEV_ADDR(DEV), .MEM_DEPTH(256), .PAGE_BYTES(32), .WCYC_CLKS(WCYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .wc_i(wc), .busy_o(busy), .ptr_o(ptr), .rd_addr_i(rd_addr), .rd_data_o(rd_data));

   int checks = 0, errors = 0;
   bit done = 0;
   logic [7:0] model_mem [256];
   int         pend_a[$];
   logic [7:0] pend_d[$];
   logic [7:0] mptr = '0, exp_ptr = '0;
   bit exp_commit = 0, busy_prev = 0;
   int bcnt = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the behavioural model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (busy && sda_oe) chk(1'b0, "R9 SDA driven during write cycle", 1, 0);
         if (busy && !busy_prev) chk(exp_commit, "R7 unexpected write cycle start", 1, int'(exp_commit));
         if (busy) bcnt++;
         if (!busy && busy_prev) begin
            chk(bcnt == WCYC, "R9 busy length", bcnt, WCYC);
            foreach (pend_a[i]) model_mem[pend_a[i]] = pend_d[i];
            pend_a.delete();
            pend_d.delete();
            chk(ptr == exp_ptr, "R10 pointer after write cycle", ptr, exp_ptr);
            exp_commit = 0;
            bcnt = 0;
         end
         if (!busy) begin
            chk(rd_data == model_mem[rd_addr], "R5/R6 memory contents", rd_data, model_mem[rd_addr]);
            rd_addr <= rd_addr + 8'd1;
         end
         busy_prev = busy;
      end
   end

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b0; wq(); scl_drv = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b1; wq();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_drv = b[i]; wq(); scl_drv = 1'b1; wq(); scl_drv = 1'b0; wq();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      sda_drv = 1'b1; wq();
      scl_drv = 1'b1;
      repeat (Q/2) @(negedge clk);
      ack = !sda_line;
      repeat (Q/2) @(negedge clk);
      scl_drv = 1'b0; wq();
   endtask

   task automatic put(input logic [7:0] b, input bit exp, input string tag);
      bit a;
      send_byte(b, a);
      chk(a == exp, tag, int'(a), int'(exp));
   endtask

   task automatic m_begin(input logic [15:0] a);
      pend_a.delete();
      pend_d.delete();
      mptr = a[7:0];
   endtask

   task automatic m_byte(input logic [7:0] b);
      pend_a.push_back(int'(mptr));
      pend_d.push_back(b);
      mptr = {mptr[7:5], mptr[4:0] + 5'd1};
   endtask

   task automatic head(input logic [15:0] a);
      bus_start();
      put({DEV, 1'b0}, 1'b1, "R1 select acknowledged");
      put(a[15:8], 1'b1, "R3 high address acknowledged");
      put(a[7:0], 1'b1, "R3 low address acknowledged");
      chk(ptr == a[7:0], "R3 pointer loaded", ptr, a[7:0]);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (300) @(negedge clk);
   endtask

   task automatic commit_stop();
      exp_ptr = mptr;
      exp_commit = 1;
      bus_stop();
      chk(busy == 1'b1, "R7 write cycle after Stop in ack slot", busy, 1);
      wait_idle();
   endtask

   task automatic nocommit_stop(input string tag);
      exp_commit = 0;
      pend_a.delete();
      pend_d.delete();
      bus_stop();
      chk(busy == 1'b0, tag, busy, 0);
      repeat (300) @(negedge clk);
   endtask

   task automatic data(input logic [7:0] b, input string tag);
      put(b, 1'b1, tag);
      m_byte(b);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) model_mem[i] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(sda_oe == 1'b0, "R11 SDA released after reset", sda_oe, 0);
      chk(busy == 1'b0, "R11 busy low after reset", busy, 0);
      chk(ptr == 8'h00, "R11 pointer zero after reset", ptr, 0);
      repeat (300) @(negedge clk);

      // R5 single byte write, 16-bit address truncated to 8 bits
      head(16'h0112); m_begin(16'h0112);
      data(8'hA5, "R5 data byte acknowledged");
      commit_stop();

      // R5 short page write
      head(16'h0040); m_begin(16'h0040);
      for (int i = 0; i < 4; i++) data(8'hC0 + 8'(i), "R5 page byte acknowledged");
      commit_stop();

      // R6 wrap at row end: 0x5E,0x5F,0x40,0x41,0x42 -> pointer 0x43
      head(16'h005E); m_begin(16'h005E);
      for (int i = 0; i < 5; i++) data(8'h70 + 8'(i), "R6 wrapping byte acknowledged");
      commit_stop();

      // R6 34-byte burst overwrites the first two buffered bytes
      head(16'h0080); m_begin(16'h0080);
      for (int i = 0; i < 34; i++) data(8'h10 + 8'(i), "R6 overwrite burst acknowledged");
      commit_stop();

      // R4 protect high during the high address byte
      bus_start();
      put({DEV, 1'b0}, 1'b1, "R4 select acknowledged");
      wc = 1'b1;
      put(8'h00, 1'b1, "R4 address acknowledged while protected");
      wc = 1'b0;
      put(8'h20, 1'b1, "R4 low address acknowledged");
      put(8'h99, 1'b0, "R4 data NoAck when protected");
      put(8'h98, 1'b0, "R4 second data NoAck when protected");
      nocommit_stop("R4 no write cycle when protected");

      // R4 protect high only during select byte
      bus_start();
      wc = 1'b1;
      put({DEV, 1'b0}, 1'b1, "R4 select acknowledged");
      wc = 1'b0;
      put(8'h00, 1'b1, "R4 address acknowledged");
      put(8'h24, 1'b1, "R4 low address acknowledged");
      put(8'h55, 1'b0, "R4 data NoAck after early protect");
      nocommit_stop("R4 no write cycle after early protect");

      // R4 protect only after address phase has no effect
      head(16'h0024); m_begin(16'h0024);
      wc = 1'b1;
      data(8'h3C, "R4 late protect ignored, data acknowledged");
      wc = 1'b0;
      commit_stop();

      // R2 wrong device address
      bus_start();
      put({7'h51, 1'b0}, 1'b0, "R2 foreign select NoAck");
      put(8'h00, 1'b0, "R2 byte after NoAck ignored");
      put(8'h10, 1'b0, "R2 byte after NoAck ignored");
      put(8'hEE, 1'b0, "R2 byte after NoAck ignored");
      nocommit_stop("R2 no write after foreign select");

      // R2 read request
      bus_start();
      put({DEV, 1'b1}, 1'b0, "R2 read select NoAck");
      put(8'h00, 1'b0, "R2 byte after read select ignored");
      nocommit_stop("R2 no write after read select");

      // R7 Stop part-way through a data byte discards
      head(16'h0030); m_begin(16'h0030);
      data(8'h77, "R7 data acknowledged");
      send_bits(8'h5A, 3);
      nocommit_stop("R7 Stop mid-byte discards");

      // R7 Stop straight after the address phase
      head(16'h0031); m_begin(16'h0031);
      nocommit_stop("R7 Stop before any data discards");

      // R8 repeated Start in address phase, then in data phase
      bus_start();
      put({DEV, 1'b0}, 1'b1, "R8 select acknowledged");
      put(8'h00, 1'b1, "R8 high address acknowledged");
      head(16'h0060); m_begin(16'h0060);
      data(8'hEE, "R8 data acknowledged");
      data(8'hEF, "R8 data acknowledged");
      head(16'h0064); m_begin(16'h0064);
      data(8'h44, "R8 new transaction data acknowledged");
      commit_stop();

      // R9 bus ignored during the write cycle
      head(16'h00A0); m_begin(16'h00A0);
      data(8'h9A, "R9 data acknowledged");
      exp_ptr = mptr;
      exp_commit = 1;
      bus_stop();
      chk(busy == 1'b1, "R9 busy after committing Stop", busy, 1);
      bus_start();
      put({DEV, 1'b0}, 1'b0, "R9 select ignored while busy");
      chk(busy == 1'b1, "R9 select sent inside write cycle", busy, 1);
      while (busy) @(negedge clk);
      bus_stop();
      repeat (300) @(negedge clk);

      // target answers again after the write cycle
      head(16'h00A1); m_begin(16'h00A1);
      data(8'h5B, "R9 target responds after write cycle");
      commit_stop();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule